// File: doc/BRIEF.md
# Memory Refresh Request Controller

This block keeps dynamic or pseudo-static memory alive by asking the bus controller for a refresh cycle at a fixed rate. A down counter counts clocks. Each time it reaches zero it reloads from a programmable interval and raises a request. The request stays up until the bus controller grants it.

While a request is up, the block presents a complete refresh address to the bus controller. The top bits come from a programmable base, so the refresh window can sit on any 8 KB boundary. The next twelve bits come from a rolling row counter, which steps once per granted cycle. The lowest address bit and the byte-high-enable output are both driven high, a combination that no ordinary data transfer uses. The cycle kind shows a memory read. Three small configuration registers set the block up: base, interval and control. The live counter value can be read back through the control register.

Top module: `rfsh_req_ctrl`

## Requirements
- R1: After reset the request is low, the cycle kind reads 3'b111 (idle), the block is disabled, and all three registers read back as zero.
- R2: Register select 0 holds the 7-bit base in read bits 6:0. Select 1 holds the 9-bit interval in read bits 8:0. Select 2 is control: bit 15 is the enable, and bits 8:0 read back the live counter. Write bits that do not fit a field are dropped, and select 3 reads zero.
- R3: A control write that sets bit 15 while the block is disabled loads the counter with the interval on that same edge.
- R4: While enabled, the counter decrements once per clock. On the edge where it is zero, it reloads the interval and raises the request, so ticks come once every interval+1 clocks.
- R5: A raised request stays high until an edge where the grant input is high. On that edge the request falls, unless a new tick raises it again.
- R6: The row counter steps by one on each edge where request and grant are both high. It wraps from 4095 to 0.
- R7: The refresh address is base in bits 19:13, row in bits 12:1, and 1 in bit 0. Byte-high-enable (active low) is driven 1. The cycle kind is 3'b101 (memory read) while the request is high, and 3'b111 otherwise.
- R8: A control write that clears bit 15 drops the request on that edge and freezes the counter. A grant while no request is up leaves the row unchanged.
- R9: When a tick and a grant land on the same edge, the request stays high and the row steps exactly once.
- R10: An interval write while running does not disturb the count in progress. The new value is used from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for writes |
| cfg_wdata | input | 16 | Write data |
| cfg_rsel | input | 2 | Register select for reads |
| cfg_rdata | output | 16 | Read data (combinational) |
| rf_req | output | 1 | Refresh request to the bus controller |
| rf_gnt | input | 1 | Grant from the bus controller |
| rf_addr | output | 20 | Refresh address |
| rf_bhe_n | output | 1 | Byte-high-enable, active low (1 during refresh) |
| rf_kind | output | 3 | Bus cycle kind: 3'b101 memory read, 3'b111 idle |

## Verification
Two events can fall on the same clock edge: the interval counter hitting zero, and a grant that retires the pending request. The bench lets a request go unanswered across one full interval. It then raises the grant exactly on the edge where the readable counter shows zero. The outcome is judged at the ports: the request must still be high after that edge, and the row field of the address must have advanced by exactly one. A further grant on the next edge must then drop the request and advance the row once more.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    localparam int RF_CNT_W  = 9;
    localparam int RF_ROW_W  = 12;
    localparam int RF_ADDR_W = 20;
    localparam int RF_DATA_W = 16;
    localparam int RF_EN_BIT = 15;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_IVAL = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        CYC_MEMRD = 3'b101,
        CYC_IDLE  = 3'b111
    } cyc_kind_e;

    function automatic cyc_kind_e kind_of(input logic req);
        return req ? CYC_MEMRD : CYC_IDLE;
    endfunction
endpackage

// File: rtl/rfsh_cfg_regs.sv
module rfsh_cfg_regs
    import rfsh_pkg::*;
#(
    parameter int CNT_W  = RF_CNT_W,
    parameter int BASE_W = RF_ADDR_W - RF_ROW_W - 1,
    parameter int DATA_W = RF_DATA_W,
    parameter int EN_BIT = RF_EN_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        rsel,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] rdata,
    output logic [BASE_W-1:0] base_o,
    output logic [CNT_W-1:0]  ival_o,
    output logic              run_o,
    output logic              start_o
);
    logic en_q;
    logic ctrl_wr;

    assign ctrl_wr = wr && (reg_sel_e'(wsel) == SEL_CTRL);
    assign start_o = ctrl_wr && wdata[EN_BIT] && !en_q;
    assign run_o   = ctrl_wr ? wdata[EN_BIT] : en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            base_o <= '0;
            ival_o <= '0;
        end else begin
            en_q <= run_o;
            if (wr && reg_sel_e'(wsel) == SEL_BASE) base_o <= wdata[BASE_W-1:0];
            if (wr && reg_sel_e'(wsel) == SEL_IVAL) ival_o <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(rsel))
            SEL_BASE: rdata[BASE_W-1:0] = base_o;
            SEL_IVAL: rdata[CNT_W-1:0]  = ival_o;
            SEL_CTRL: begin
                rdata[EN_BIT]     = en_q;
                rdata[CNT_W-1:0]  = cnt_i;
            end
            default:  rdata = '0;
        endcase
    end

    AST_START_ENABLES: assert property (@(posedge clk) disable iff (rst)
        start_o |=> en_q); // R3
    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(en_q)); // R2
endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
    parameter int CNT_W = rfsh_pkg::RF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] ival_i,
    input  logic             gnt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             req_o,
    output logic             take_o
);
    logic tick;

    assign tick   = run_i && !start_i && (cnt_o == '0);
    assign take_o = req_o && gnt_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            req_o <= 1'b0;
        end else begin
            if (start_i)      cnt_o <= ival_i;
            else if (tick)    cnt_o <= ival_i;
            else if (run_i)   cnt_o <= cnt_o - 1'b1;

            if (!run_i)       req_o <= 1'b0;
            else if (tick)    req_o <= 1'b1;
            else if (take_o)  req_o <= 1'b0;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        run_i && req_o && !gnt_i |=> req_o); // R5
    AST_DROP_OFF: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !req_o); // R8
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> $stable(cnt_o)); // R8
    AST_TICK_RAISES: assert property (@(posedge clk) disable iff (rst)
        run_i && !start_i && cnt_o == '0 |=> req_o); // R4
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        run_i && !start_i && cnt_o != '0 |=> cnt_o == $past(cnt_o) - 1'b1); // R4
endmodule

// File: rtl/rfsh_row_addr.sv
module rfsh_row_addr #(
    parameter int ROW_W  = rfsh_pkg::RF_ROW_W,
    parameter int ADDR_W = rfsh_pkg::RF_ADDR_W,
    localparam int BASE_W = ADDR_W - ROW_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [BASE_W-1:0] base_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst)         row_q <= '0;
        else if (take_i) row_q <= row_q + 1'b1;
    end

    assign addr_o = {base_i, row_q, 1'b1};

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        take_i |=> row_q == $past(row_q) + 1'b1); // R6
    AST_ROW_STILL: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> $stable(row_q)); // R8
endmodule

// File: rtl/rfsh_req_ctrl.sv
module rfsh_req_ctrl
    import rfsh_pkg::*;
#(
    parameter int CNT_W  = RF_CNT_W,
    parameter int ROW_W  = RF_ROW_W,
    parameter int ADDR_W = RF_ADDR_W,
    parameter int DATA_W = RF_DATA_W,
    localparam int BASE_W = ADDR_W - ROW_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [1:0]        cfg_rsel,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              rf_req,
    input  logic              rf_gnt,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_bhe_n,
    output logic [2:0]        rf_kind
);
    logic [BASE_W-1:0] base;
    logic [CNT_W-1:0]  ival;
    logic [CNT_W-1:0]  cnt;
    logic              run;
    logic              start;
    logic              take;

    rfsh_cfg_regs #(
        .CNT_W(CNT_W), .BASE_W(BASE_W), .DATA_W(DATA_W), .EN_BIT(DATA_W - 1)
    ) u_regs (
        .clk(clk), .rst(rst), .wr(cfg_wr), .wsel(cfg_sel), .wdata(cfg_wdata),
        .rsel(cfg_rsel), .cnt_i(cnt), .rdata(cfg_rdata), .base_o(base),
        .ival_o(ival), .run_o(run), .start_o(start)
    );

    rfsh_interval #(.CNT_W(CNT_W)) u_ival (
        .clk(clk), .rst(rst), .run_i(run), .start_i(start), .ival_i(ival),
        .gnt_i(rf_gnt), .cnt_o(cnt), .req_o(rf_req), .take_o(take)
    );

    rfsh_row_addr #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_row (
        .clk(clk), .rst(rst), .take_i(take), .base_i(base), .addr_o(rf_addr)
    );

    assign rf_bhe_n = 1'b1;
    assign rf_kind  = kind_of(rf_req);

    AST_KIND_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
        rf_req |-> rf_kind == 3'b101); // R7
endmodule

// File: tb/tb_rfsh_req_ctrl.sv
module tb_rfsh_req_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [1:0]  cfg_rsel = 2'd0;
    logic [15:0] cfg_rdata;
    logic        rf_req;
    logic        rf_gnt = 1'b0;
    logic [19:0] rf_addr;
    logic        rf_bhe_n;
    logic [2:0]  rf_kind;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    rfsh_req_ctrl dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .rf_req(rf_req), .rf_gnt(rf_gnt), .rf_addr(rf_addr),
        .rf_bhe_n(rf_bhe_n), .rf_kind(rf_kind)
    );

    always #5 clk = ~clk;

    // sel, write data, expected read data
    localparam logic [33:0] VEC [7] = '{
        {2'd0, 16'hFFFF, 16'h007F},
        {2'd1, 16'hFFFF, 16'h01FF},
        {2'd0, 16'h0055, 16'h0055},
        {2'd1, 16'h0000, 16'h0000},
        {2'd0, 16'h002A, 16'h002A},
        {2'd1, 16'h0003, 16'h0003},
        {2'd2, 16'h0000, 16'h0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [31:0] rd(input logic [1:0] sel);
        cfg_rsel = sel;
        return 32'(cfg_rdata);
    endfunction

    task automatic rdchk(input string tag, input logic [1:0] sel, input logic [15:0] exp);
        cfg_rsel = sel;
        #1;
        check(tag, 32'(cfg_rdata), 32'(exp));
    endtask

    function automatic logic [19:0] addr_of(input logic [6:0] b, input logic [11:0] r);
        return {b, r, 1'b1};
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        check("R1 req", 32'(rf_req), 32'd0);
        check("R1 kind", 32'(rf_kind), 32'h7);
        rdchk("R1 base", 2'd0, 16'h0000);
        rdchk("R1 ival", 2'd1, 16'h0000);
        rdchk("R1 ctrl", 2'd2, 16'h0000);
        check("R7 addr after reset", 32'(rf_addr), 32'h00001);
        check("R7 bhe_n", 32'(rf_bhe_n), 32'd1);

        // R2 register vectors
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][33:32], VEC[i][31:16]);
            rdchk("R2 readback", VEC[i][33:32], VEC[i][15:0]);
        end
        rdchk("R2 unused select", 2'd3, 16'h0000);
        check("R7 base in addr", 32'(rf_addr), 32'(addr_of(7'h2A, 12'd0)));

        // R3 enable loads interval (3)
        wr(2'd2, 16'h8000);
        rdchk("R3 load on enable", 2'd2, 16'h8003);
        step(3);
        rdchk("R4 counted to zero", 2'd2, 16'h8000);
        check("R4 no req yet", 32'(rf_req), 32'd0);
        step(1);
        check("R4 req on tick", 32'(rf_req), 32'd1);
        rdchk("R4 reload", 2'd2, 16'h8003);
        check("R7 kind memrd", 32'(rf_kind), 32'h5);
        check("R7 addr row0", 32'(rf_addr), 32'(addr_of(7'h2A, 12'd0)));

        // R5/R6 grant
        rf_gnt = 1'b1; step(1); rf_gnt = 1'b0;
        check("R5 req drops on grant", 32'(rf_req), 32'd0);
        check("R6 row steps", 32'(rf_addr), 32'(addr_of(7'h2A, 12'd1)));
        step(3);
        check("R4 period interval+1", 32'(rf_req), 32'd1);
        step(4);
        check("R5 held without grant", 32'(rf_req), 32'd1);
        check("R6 no step without grant", 32'(rf_addr), 32'(addr_of(7'h2A, 12'd1)));

        // R9 tick and grant on the same edge
        step(3);
        rdchk("R9 counter at zero", 2'd2, 16'h8000);
        rf_gnt = 1'b1; step(1);
        check("R9 req stays high", 32'(rf_req), 32'd1);
        check("R9 row steps once", 32'(rf_addr), 32'(addr_of(7'h2A, 12'd2)));
        step(1); rf_gnt = 1'b0;
        check("R5 second grant drops req", 32'(rf_req), 32'd0);
        check("R6 row 3", 32'(rf_addr), 32'(addr_of(7'h2A, 12'd3)));

        // R10 interval change mid count (counter was 2)
        wr(2'd1, 16'h0001);
        rdchk("R10 count undisturbed", 2'd2, 16'h8001);
        step(1);
        check("R10 no early tick", 32'(rf_req), 32'd0);
        step(1);
        check("R10 tick", 32'(rf_req), 32'd1);
        rdchk("R10 new interval on reload", 2'd2, 16'h8001);
        rf_gnt = 1'b1; step(1); rf_gnt = 1'b0;
        step(1);
        check("R10 period two", 32'(rf_req), 32'd1);

        // R8 disable
        wr(2'd2, 16'h0000);
        check("R8 req dropped", 32'(rf_req), 32'd0);
        check("R8 kind idle", 32'(rf_kind), 32'h7);
        rdchk("R8 counter frozen", 2'd2, 16'h0001);
        step(3);
        rdchk("R8 counter still frozen", 2'd2, 16'h0001);
        rf_gnt = 1'b1; step(1); rf_gnt = 1'b0;
        check("R8 stray grant ignored", 32'(rf_addr), 32'(addr_of(7'h2A, 12'd4)));

        // R6 wrap with interval 0 and grant held
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h8000);
        step(1);
        check("R4 interval zero tick", 32'(rf_req), 32'd1);
        rf_gnt = 1'b1;
        for (int k = 0; k < 5000 && rf_addr[12:1] != 12'hFFF; k++) step(1);
        check("R6 reached top", 32'(rf_addr), 32'(addr_of(7'h2A, 12'hFFF)));
        step(1);
        check("R6 wrap to zero", 32'(rf_addr), 32'(addr_of(7'h2A, 12'h000)));
        check("R9 continuous ticks keep req", 32'(rf_req), 32'd1);
        rf_gnt = 1'b0;

        // R1 reset again
        rst = 1'b1; step(1); rst = 1'b0;
        check("R1 req after reset", 32'(rf_req), 32'd0);
        rdchk("R1 ctrl after reset", 2'd2, 16'h0000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule